// File: doc/BRIEF.md
# Matched Filter and Fractional Resampler

This block is the front of a chip-rate baseband receiver. Signed demodulator samples arrive with a valid strobe at an oversampling rate between 8 and 16 samples per chip. A boxcar matched filter adds up the most recent `cfg_len` samples. The configuration sets that window to the oversampling factor, so one chip's worth of energy is collected.

A linear-interpolation resampler follows the filter. Its phase step is the ratio of input rate to output rate, from 1.0 to 2.0. With the step chosen to match the input rate, the output runs at exactly 8 samples per chip. A bypass selection skips the resampler and presents the filtered stream directly.

A sign slicer turns the current output sample into a raw chip bit. The bit's polarity can be inverted. The configuration inputs are meant to be set while reset is held and kept constant afterwards.

Top module: `mf_resampler`

## Requirements
- R1: While `rst` is high on a clock edge, `y_valid` is low after that edge. After reset, `y_valid` stays low until at least `cfg_len` input strobes have been accepted.
- R2: In bypass mode, every accepted input from the `cfg_len`-th one onward gives one `y_valid` pulse one cycle later. `y_data` then equals the signed sum of the latest `cfg_len` inputs.
- R3: Any window length from 8 to 16 gives the sum described in R2.
- R4: A step of 0x10000 (1.0 in unsigned 1.16 format) reproduces the filtered sequence value for value. Each value appears one filtered sample later than in bypass.
- R5: A resampled output between filtered samples a (older) and b (newer), with phase fraction f (16 bits), equals a + floor(((b - a) * f + 32768) / 65536).
- R6: The phase starts at 0 after reset and is updated on each filtered sample after the first. If the phase is below 1.0, one output is produced and the phase becomes phase + step - 1.0. Otherwise no output is produced and the phase decreases by 1.0. For example, a step of 0x20000 halves the rate.
- R7: The resampler produces at most one output per accepted input. That output appears two cycles after the input strobe.
- R8: When `cfg_bypass` is high, the output stream is the filtered stream, with no interpolation.
- R9: `raw_bit` is 1 when `y_data` is non-negative (bit 15 clear) and 0 when it is negative. Both values are swapped when `cfg_invert` is 1.
- R10: Full-scale inputs (all +2047 or all -2048) over a 16-sample window give +32752 and -32768 with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 12 | Signed demodulator sample |
| cfg_len | input | 5 | Filter window length, 8 to 16 |
| cfg_step | input | 17 | Phase step, unsigned 1.16, 0x10000 to 0x20000 |
| cfg_bypass | input | 1 | 1: output the filtered stream directly |
| cfg_invert | input | 1 | 1: invert the raw bit polarity |
| y_valid | output | 1 | Output sample strobe |
| y_data | output | 16 | Signed output sample |
| raw_bit | output | 1 | Sliced chip bit of `y_data` |

## Verification
The assertions assume the following about the inputs:
- `cfg_len`, `cfg_step`, `cfg_bypass` and `cfg_invert` stay constant from reset onward.
- The window length is between 8 and 16.
- The step is between 1.0 and 2.0.

Under these assumptions, output latency and interpolation bounds are fixed properties. The stimulus changes configuration only while reset is held. Each case begins with a fresh reset. The bench drives only legal lengths and steps, with input strobes either on every cycle or on alternate cycles.

// File: rtl/mfr_pkg.sv
package mfr_pkg;
   // selects where the output stage takes its samples from
   typedef enum logic {
      PATH_RESAMPLED = 1'b0,
      PATH_FILTERED  = 1'b1
   } out_path_e;

   localparam int DEF_SAMPLE_W = 12;
   localparam int DEF_MIN_LEN  = 8;
   localparam int DEF_MAX_LEN  = 16;
   localparam int DEF_FRAC_W   = 16;
endpackage

// File: rtl/mf_boxcar.sv
module mf_boxcar #(
   parameter int SW      = 12,
   parameter int MAX_LEN = 16,
   parameter int AW      = 16,
   parameter int LW      = 5
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic signed [SW-1:0] in_data,
   input  logic [LW-1:0]        len,
   output logic                 f_valid,
   output logic signed [AW-1:0] f_data
);
   logic signed [SW-1:0] tap_q [MAX_LEN];
   logic signed [SW-1:0] leaving;
   logic signed [AW-1:0] sum_next;
   logic [LW-1:0]        fill_q;
   logic                 full_now;

   // sample that drops out of the window when a new one is pushed
   always_comb begin
      leaving = '0;
      for (int i = 0; i < MAX_LEN; i++) begin
         if (LW'(i + 1) == len) leaving = tap_q[i];
      end
   end

   assign sum_next = f_data + AW'(in_data) - AW'(leaving);
   assign full_now = ({1'b0, fill_q} + (LW+1)'(1)) >= {1'b0, len};

   for (genvar i = 0; i < MAX_LEN; i++) begin : g_tap
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst)           tap_q[i] <= '0;
            else if (in_valid) tap_q[i] <= in_data;
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (rst)           tap_q[i] <= '0;
            else if (in_valid) tap_q[i] <= tap_q[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         f_data  <= '0;
         fill_q  <= '0;
         f_valid <= 1'b0;
      end else begin
         f_valid <= in_valid && full_now;
         if (in_valid) begin
            f_data <= sum_next;
            if (fill_q < len) fill_q <= fill_q + LW'(1);
         end
      end
   end
endmodule

// File: rtl/frac_resampler.sv
module frac_resampler #(
   parameter int AW = 16,
   parameter int FB = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 s_valid,
   input  logic signed [AW-1:0] s_data,
   input  logic [FB:0]          step,
   output logic                 r_valid,
   output logic signed [AW-1:0] r_data,
   output logic signed [AW-1:0] hold_o
);
   localparam logic [FB:0] UNIT = (FB+1)'(1) << FB;
   localparam int          PW   = AW + FB + 2;

   logic signed [AW-1:0] prev_q;
   logic                 primed_q;
   logic [FB:0]          ph_q;
   logic                 below_one;
   logic signed [AW:0]   diff;
   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] rounded;
   logic signed [AW-1:0] interp;

   assign below_one = ~ph_q[FB];
   assign diff      = (AW+1)'(s_data) - (AW+1)'(prev_q);
   assign prod      = diff * $signed({1'b0, ph_q[FB-1:0]});
   assign rounded   = (prod + (PW'(1) <<< (FB-1))) >>> FB;
   assign interp    = prev_q + rounded[AW-1:0];
   assign hold_o    = prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q   <= '0;
         primed_q <= 1'b0;
         ph_q     <= '0;
         r_valid  <= 1'b0;
         r_data   <= '0;
      end else begin
         r_valid <= 1'b0;
         if (s_valid) begin
            prev_q   <= s_data;
            primed_q <= 1'b1;
            if (primed_q) begin
               if (below_one) begin
                  r_valid <= 1'b1;
                  r_data  <= interp;
                  ph_q    <= ph_q + step - UNIT;
               end else begin
                  ph_q    <= ph_q - UNIT;
               end
            end
         end
      end
   end
endmodule

// File: rtl/sign_slicer.sv
module sign_slicer #(
   parameter int AW = 16
) (
   input  logic signed [AW-1:0] sample,
   input  logic                 invert,
   output logic                 bit_o
);
   assign bit_o = ~sample[AW-1] ^ invert;
endmodule

// File: rtl/mf_resampler.sv
module mf_resampler
   import mfr_pkg::*;
#(
   parameter int  SW        = DEF_SAMPLE_W,
   parameter int  MIN_LEN   = DEF_MIN_LEN,
   parameter int  MAX_LEN   = DEF_MAX_LEN,
   parameter int  FB        = DEF_FRAC_W,
   parameter bit  BYPASS_EN = 1'b1,
   localparam int AW        = SW + $clog2(MAX_LEN),
   localparam int LW        = $clog2(MAX_LEN + 1)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic signed [SW-1:0] in_data,
   input  logic [LW-1:0]        cfg_len,
   input  logic [FB:0]          cfg_step,
   input  logic                 cfg_bypass,
   input  logic                 cfg_invert,
   output logic                 y_valid,
   output logic signed [AW-1:0] y_data,
   output logic                 raw_bit
);
   if (SW < 2) begin : g_bad_sw
      $error("mf_resampler: SW must be at least 2");
   end
   if (MIN_LEN < 2 || MAX_LEN < MIN_LEN) begin : g_bad_len
      $error("mf_resampler: need 2 <= MIN_LEN <= MAX_LEN");
   end
   if (FB < 2) begin : g_bad_fb
      $error("mf_resampler: FB must be at least 2");
   end

   logic                 f_valid;
   logic signed [AW-1:0] f_data;
   logic                 r_valid;
   logic signed [AW-1:0] r_data;
   logic signed [AW-1:0] rs_hold;
   out_path_e            path;

   mf_boxcar #(.SW(SW), .MAX_LEN(MAX_LEN), .AW(AW), .LW(LW)) u_filt (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_data  (in_data),
      .len      (cfg_len),
      .f_valid  (f_valid),
      .f_data   (f_data)
   );

   frac_resampler #(.AW(AW), .FB(FB)) u_rs (
      .clk     (clk),
      .rst     (rst),
      .s_valid (f_valid),
      .s_data  (f_data),
      .step    (cfg_step),
      .r_valid (r_valid),
      .r_data  (r_data),
      .hold_o  (rs_hold)
   );

   if (BYPASS_EN) begin : g_mux
      assign path = cfg_bypass ? PATH_FILTERED : PATH_RESAMPLED;
   end else begin : g_fixed
      assign path = PATH_RESAMPLED;
   end

   assign y_valid = (path == PATH_FILTERED) ? f_valid : r_valid;
   assign y_data  = (path == PATH_FILTERED) ? f_data  : r_data;

   sign_slicer #(.AW(AW)) u_slice (
      .sample (y_data),
      .invert (cfg_invert),
      .bit_o  (raw_bit)
   );
endmodule

// File: rtl/mf_resampler_chk.sv
module mf_resampler_chk #(
   parameter int AW = 16,
   parameter int LW = 5
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 in_valid,
   input logic [LW-1:0]        cfg_len,
   input logic                 cfg_bypass,
   input logic                 cfg_invert,
   input logic                 y_valid,
   input logic signed [AW-1:0] y_data,
   input logic                 raw_bit,
   input logic signed [AW-1:0] f_data,
   input logic signed [AW-1:0] hold
);
   logic [LW:0] seen_q;

   always_ff @(posedge clk) begin
      if (rst)                                 seen_q <= '0;
      else if (in_valid && seen_q < {1'b0, cfg_len}) seen_q <= seen_q + (LW+1)'(1);
   end

   // R1: reset quiets the strobe
   a_r1_reset_quiet: assert property (@(posedge clk) $past(rst) |-> !y_valid);

   // R1: no strobe before the window has been filled
   a_r1_fill_first: assert property (@(posedge clk) disable iff (rst)
      y_valid |-> (seen_q >= {1'b0, cfg_len}));

   // R7: bypass output one cycle after its input strobe
   a_r7_bypass_latency: assert property (@(posedge clk) disable iff (rst)
      (y_valid && cfg_bypass) |-> $past(in_valid));

   // R7: resampled output two cycles after its input strobe
   a_r7_resample_latency: assert property (@(posedge clk) disable iff (rst)
      (y_valid && !cfg_bypass) |-> $past(in_valid, 2));

   // R5: interpolated value lies between its two neighbours
   a_r5_bounded: assert property (@(posedge clk) disable iff (rst)
      (y_valid && !cfg_bypass) |->
         (($past(hold) <= y_data && y_data <= $past(f_data)) ||
          ($past(f_data) <= y_data && y_data <= $past(hold))));

   // R9: the raw bit only moves when the sample or the polarity moves
   a_r9_raw_follows: assert property (@(posedge clk) disable iff (rst)
      ($stable(y_data) && $stable(cfg_invert)) |-> $stable(raw_bit));
endmodule

bind mf_resampler mf_resampler_chk #(.AW(AW), .LW(LW)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .cfg_len    (cfg_len),
   .cfg_bypass (cfg_bypass),
   .cfg_invert (cfg_invert),
   .y_valid    (y_valid),
   .y_data     (y_data),
   .raw_bit    (raw_bit),
   .f_data     (f_data),
   .hold       (rs_hold)
);

// File: tb/test_mf_resampler.sv
module test_mf_resampler;
   localparam int SW  = 12;
   localparam int AW  = 16;
   localparam int ONE = 65536;

   logic                 clk = 1'b0;
   logic                 rst;
   logic                 in_valid;
   logic signed [SW-1:0] in_data;
   logic [4:0]           cfg_len;
   logic [16:0]          cfg_step;
   logic                 cfg_bypass;
   logic                 cfg_invert;
   logic                 y_valid;
   logic signed [AW-1:0] y_data;
   logic                 raw_bit;

   int total = 0;
   int bad   = 0;
   logic cap = 1'b0;
   int got_y[$];
   int got_raw[$];

   always #2 clk = ~clk;

   mf_resampler i_mf_resampler (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .cfg_len(cfg_len), .cfg_step(cfg_step), .cfg_bypass(cfg_bypass),
      .cfg_invert(cfg_invert), .y_valid(y_valid), .y_data(y_data),
      .raw_bit(raw_bit)
   );

   always @(negedge clk) begin
      if (cap && y_valid) begin
         got_y.push_back(int'(y_data));
         got_raw.push_back(raw_bit ? 1 : 0);
      end
   end

   task automatic chk(string tag, int act, int exp, string what);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int smp(int mode, int i);
      case (mode)
         0:       return ((i * 733 + 91) % 4096) - 2048;
         1:       return 2047;
         2:       return -2048;
         default: return ((i / 8) % 2 == 1) ? 2047 : -2047;
      endcase
   endfunction

   function automatic longint lerp(longint a, longint b, longint f);
      longint t;
      t = (b - a) * f + 32768;
      return a + (t >>> 16);
   endfunction

   task automatic run_case(string tag, int len, int step, bit byp, bit inv,
                           int mode, bit gap, int n);
      int xs[$];
      int fl[$];
      int ex[$];
      longint ph;
      longint prev;
      bit primed;
      rst = 1'b1; in_valid = 1'b0; in_data = '0;
      cfg_len = 5'(len); cfg_step = 17'(step);
      cfg_bypass = byp; cfg_invert = inv;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      got_y.delete(); got_raw.delete();
      cap = 1'b1;
      chk("R1", y_valid ? 1 : 0, 0, "valid after reset");
      for (int i = 0; i < n; i++) begin
         xs.push_back(smp(mode, i));
         in_data  = SW'(xs[i]);
         in_valid = 1'b1;
         @(negedge clk);
         if (gap) begin
            in_valid = 1'b0;
            @(negedge clk);
         end
         if (i == len - 2) begin
            in_valid = 1'b0;
            repeat (3) @(negedge clk);
            chk("R1", got_y.size(), 0, "strobes before window full");
         end
      end
      in_valid = 1'b0;
      repeat (5) @(negedge clk);
      cap = 1'b0;
      // reference: boxcar sums, then phase-stepped interpolation
      for (int i = len - 1; i < n; i++) begin
         int s;
         s = 0;
         for (int j = 0; j < len; j++) s += xs[i - j];
         fl.push_back(s);
      end
      if (byp) begin
         ex = fl;
      end else begin
         ph = 0; prev = 0; primed = 1'b0;
         foreach (fl[k]) begin
            if (primed) begin
               if (ph < ONE) begin
                  ex.push_back(int'(lerp(prev, longint'(fl[k]), ph)));
                  ph = ph + step - ONE;
               end else begin
                  ph = ph - ONE;
               end
            end
            prev = fl[k];
            primed = 1'b1;
         end
      end
      chk(tag, got_y.size(), ex.size(), "output count");
      chk("R7", (got_y.size() <= n) ? 1 : 0, 1, "outputs bounded by inputs");
      for (int k = 0; k < got_y.size() && k < ex.size(); k++) begin
         chk(tag, got_y[k], ex[k], "sample value");
         chk("R9", got_raw[k], ((ex[k] >= 0) ? 1 : 0) ^ (inv ? 1 : 0), "raw bit");
      end
   endtask

   initial begin
      #600000;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst = 1'b1; in_valid = 1'b0; in_data = '0;
      cfg_len = 5'd8; cfg_step = 17'(ONE); cfg_bypass = 1'b1; cfg_invert = 1'b0;
      run_case("R2", 8, ONE, 1'b1, 1'b0, 0, 1'b0, 40);
      run_case("R8", 11, ONE, 1'b1, 1'b1, 0, 1'b1, 40);
      for (int L = 8; L <= 16; L++) begin
         run_case("R3", L, ONE, 1'b1, 1'b0, 3, 1'b0, 36);
      end
      run_case("R10", 16, ONE, 1'b1, 1'b0, 1, 1'b0, 30);
      run_case("R10", 16, ONE, 1'b1, 1'b1, 2, 1'b0, 30);
      run_case("R10", 16, 'h18000, 1'b0, 1'b0, 3, 1'b0, 60);
      run_case("R4", 12, ONE, 1'b0, 1'b0, 0, 1'b0, 40);
      run_case("R5", 8, 'h18000, 1'b0, 1'b1, 3, 1'b0, 48);
      run_case("R5", 10, 'h15555, 1'b0, 1'b0, 0, 1'b1, 48);
      run_case("R6", 16, 'h20000, 1'b0, 1'b0, 0, 1'b1, 50);
      run_case("R6", 9, 'h1C000, 1'b0, 1'b0, 0, 1'b0, 50);
      run_case("R7", 8, 'h13333, 1'b0, 1'b0, 0, 1'b0, 40);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule